// File: doc/BRIEF.md
# Segment Register Descriptor Loader

This block loads one of several data or stack segment registers from a 16-bit selector and keeps the hidden cache for each of them. In protected mode it splits the selector into table index, table choice and requested privilege. It checks the index against the global or local table bound and reads the 8-byte descriptor as two 32-bit words over a request/response memory port. It then decodes the descriptor, runs the privilege, type and presence rules, and either signals a fault with a kind and an error code, or fills the cache and writes back the accessed flag.

In real mode and virtual-8086 mode a load completes in one cycle without touching memory. The table bases and bounds are written through a small side port. Any cache entry can be read at any time through a combinational read port. Segment identifiers run from 0 to NUM_SEG-1. The entry numbered STACK_ID (default 1) follows the stack rules and every other entry follows the data rules.

Top module: `seg_loader`

## Requirements
- R1: A protected-mode load reads the low descriptor word at table_base + index*8 and the high word at table_base + index*8 + 4. The index is selector bits 15:3. Selector bit 2 picks the local table when 1 and the global table when 0. Selector bits 1:0 are the requested privilege.
- R2: A selector with bits 15:2 all zero makes no memory access. For a data entry, the entry's valid flag and selector are cleared and done pulses. For the stack entry, a general-protection fault (kind 1) with error code 0 is raised.
- R3: When index*8+7 is greater than the chosen table's bound, or the local table is chosen while it is marked invalid, a general-protection fault is raised without any memory read. Its error code is the selector with bits 1:0 cleared.
- R4: On success the entry holds the selector and a base made of low[31:16] with high[7:0] as bits 23:16 and high[31:24] as bits 31:24. The 20-bit limit is low[15:0] with high[19:16] above it. When high bit 23 is set, that limit is shifted left by 12 with 0xFFF filled in, except that an expand-down data segment (type bit 3 clear, bit 2 set) gets no fill. The entry also holds the access byte (high[15:8]) with bit 0 set, and flags {high[23], high[22], high[20]}.
- R5: A stack load checks, in this order: requested privilege equals current privilege; the segment is writable data (access bit 4 set, bit 3 clear, bit 1 set); descriptor privilege (access bits 6:5) equals current privilege. Each of these failures is a general-protection fault. After them, a clear present bit (access bit 7) gives a stack fault (kind 2).
- R6: A data load faults general-protection unless the descriptor is data, or code with the readable bit set. For data or non-conforming code (type bit 2 clear), requested and current privilege must both be at most the descriptor privilege, otherwise general-protection. Then a clear present bit gives a not-present fault (kind 3).
- R7: After a successful protected load the high word with bit 8 set is written to table_base + index*8 + 4. A stack load always writes. A data load writes only when bit 8 was clear.
- R8: A fault leaves every cache entry unchanged and issues no memory write.
- R9: In real mode (mode 0) the entry gets the selector, base selector<<4 and valid. Its access byte has bits 7, 4 and 0 set, and its limit, flags and other access bits are kept. done pulses in the cycle after start.
- R10: In virtual-8086 mode (mode bit 1 set) the entry gets the selector, base selector<<4, limit 0xFFFF, access byte 0xF3 and flags 0. done pulses in the cycle after start.
- R11: busy is high from the cycle after a protected load is accepted and falls in the cycle in which done or fault pulses for one cycle. A start while busy is ignored. A start in the cycle of a done pulse is accepted. With a memory that answers at once, a load without write-back pulses done 5 cycles after the accepting edge.
- R12: After reset the block is idle, all entries read invalid with zero contents, and the global bound is 0 with the local table marked invalid.
- R13: A memory request holds its address, write flag and data until ready is seen, and a read completes only on a response strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load |
| seg_id | input | ID_W | Entry to load |
| sel_in | input | 16 | Selector to load |
| mode | input | 2 | 0 real, 1 protected, 2 or 3 virtual-8086 |
| cpl | input | 2 | Current privilege level |
| tbl_we | input | 1 | Write a table register |
| tbl_local | input | 1 | 1 writes the local table, 0 the global |
| tbl_valid | input | 1 | Valid flag for the local table |
| tbl_base | input | 32 | Table base address |
| tbl_limit | input | 32 | Table bound in bytes |
| busy | output | 1 | Protected load in progress |
| done | output | 1 | Load completed pulse |
| fault | output | 1 | Load faulted pulse |
| fault_kind | output | 2 | 1 general-protection, 2 stack, 3 not-present |
| fault_code | output | 16 | Error code |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| rd_id | input | ID_W | Entry to observe |
| rd_valid | output | 1 | Entry valid |
| rd_sel | output | 16 | Entry selector |
| rd_base | output | 32 | Entry base |
| rd_limit | output | 32 | Entry scaled limit |
| rd_attr | output | 8 | Entry access byte |
| rd_flags | output | 3 | Entry granularity, default size, available |

## Verification
The bench starts a new load in the very cycle in which the previous load pulses done. This happens whenever one directed load follows another, since each task returns on the done cycle and the next one raises start at once. The second load is judged by the entry it leaves behind. The other collision is a start that arrives while a descriptor fetch is under way. The bench raises it with a real-mode request that would otherwise update an entry immediately, and then checks that the entry's selector and base still hold their earlier values after the first load finishes.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;

    localparam int SEL_W  = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_GP    = 2'd1,
        FK_STACK = 2'd2,
        FK_NP    = 2'd3
    } fault_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_LO,
        S_WT_LO,
        S_RD_HI,
        S_WT_HI,
        S_CHECK,
        S_WBACK
    } ld_state_e;

    typedef struct packed {
        logic              valid;
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] limit;
        logic [7:0]        attr;
        logic [2:0]        flags;
    } seg_cache_t;

endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
    import seg_ld_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] gbase,
    input  logic [WORD_W-1:0] glimit,
    input  logic [WORD_W-1:0] lbase,
    input  logic [WORD_W-1:0] llimit,
    input  logic              lvalid,
    output logic              is_null,
    output logic              bound_fault,
    output logic [WORD_W-1:0] desc_addr
);
    logic [WORD_W-1:0] offs;
    logic [WORD_W-1:0] last_byte;

    always_comb begin
        offs      = {{(WORD_W-SEL_W){1'b0}}, sel[SEL_W-1:3], 3'b000};
        last_byte = {{(WORD_W-SEL_W){1'b0}}, sel[SEL_W-1:3], 3'b111};
        is_null   = (sel[SEL_W-1:2] == '0);
        if (sel[2]) begin
            bound_fault = !lvalid || (last_byte > llimit);
            desc_addr   = lbase + offs;
        end else begin
            bound_fault = (last_byte > glimit);
            desc_addr   = gbase + offs;
        end
    end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_ld_pkg::*;
(
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        cpl,
    input  logic              is_stack,
    output fault_kind_e       kind,
    output logic              need_wb,
    output logic [WORD_W-1:0] wb_word,
    output seg_cache_t        entry
);
    logic [7:0]  acc;
    logic [1:0]  dpl;
    logic [1:0]  rpl;
    logic        present, is_seg, exe, conf_ed, rd_wr, touched;
    logic [19:0] lim20;

    always_comb begin
        acc     = hi[15:8];
        present = acc[7];
        dpl     = acc[6:5];
        is_seg  = acc[4];
        exe     = acc[3];
        conf_ed = acc[2];
        rd_wr   = acc[1];
        touched = acc[0];
        rpl     = sel[1:0];
        lim20   = {hi[19:16], lo[15:0]};

        entry.valid = 1'b1;
        entry.sel   = sel;
        entry.base  = {hi[31:24], hi[7:0], lo[31:16]};
        entry.attr  = acc | 8'h01;
        entry.flags = {hi[23], hi[22], hi[20]};
        if (!hi[23])
            entry.limit = {12'h000, lim20};
        else if (!exe && conf_ed)
            entry.limit = {lim20, 12'h000};
        else
            entry.limit = {lim20, 12'hFFF};

        wb_word = hi | 32'h0000_0100;
        kind    = FK_NONE;
        if (is_stack) begin
            need_wb = 1'b1;
            if (rpl != cpl)
                kind = FK_GP;
            else if (!(is_seg && !exe && rd_wr))
                kind = FK_GP;
            else if (dpl != cpl)
                kind = FK_GP;
            else if (!present)
                kind = FK_STACK;
        end else begin
            need_wb = !touched;
            if (!is_seg || (exe && !rd_wr))
                kind = FK_GP;
            else if ((!exe || !conf_ed) && ((rpl > dpl) || (cpl > dpl)))
                kind = FK_GP;
            else if (!present)
                kind = FK_NP;
        end
    end
endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
    import seg_ld_pkg::*;
#(
    parameter int NUM_SEG = 5,
    parameter int ID_W    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [ID_W-1:0] wid,
    input  seg_cache_t      wdata,
    input  logic [ID_W-1:0] rd_id,
    output seg_cache_t      rd_entry,
    input  logic [ID_W-1:0] mg_id,
    output seg_cache_t      mg_entry
);
    seg_cache_t ent_q [NUM_SEG];
    seg_cache_t ent_d [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (we && (wid == ID_W'(g)))
                ent_d[g] = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d[g];
        end
    end

    always_comb begin
        rd_entry = '0;
        mg_entry = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_id == ID_W'(i)) rd_entry = ent_q[i];
            if (mg_id == ID_W'(i)) mg_entry = ent_q[i];
        end
    end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import seg_ld_pkg::*;
#(
    parameter int NUM_SEG  = 5,
    parameter int STACK_ID = 1,
    localparam int ID_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   seg_id,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [1:0]        mode,
    input  logic [1:0]        cpl,
    input  logic              tbl_we,
    input  logic              tbl_local,
    input  logic              tbl_valid,
    input  logic [WORD_W-1:0] tbl_base,
    input  logic [WORD_W-1:0] tbl_limit,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_kind,
    output logic [SEL_W-1:0]  fault_code,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    input  logic [ID_W-1:0]   rd_id,
    output logic              rd_valid,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_base,
    output logic [WORD_W-1:0] rd_limit,
    output logic [7:0]        rd_attr,
    output logic [2:0]        rd_flags
);
    typedef struct packed {
        ld_state_e         st;
        logic [ID_W-1:0]   id;
        logic [SEL_W-1:0]  sel;
        logic [1:0]        cpl;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] wdata;
        logic              done;
        logic              fault;
        fault_kind_e       kind;
        logic [SEL_W-1:0]  code;
        logic [WORD_W-1:0] gbase;
        logic [WORD_W-1:0] glimit;
        logic [WORD_W-1:0] lbase;
        logic [WORD_W-1:0] llimit;
        logic              lvalid;
    } regs_t;

    regs_t q, d;

    logic              sc_null, sc_bound;
    logic [WORD_W-1:0] sc_addr;
    fault_kind_e       dc_kind;
    logic              dc_wb;
    logic [WORD_W-1:0] dc_wword;
    seg_cache_t        dc_entry;

    logic              cwe;
    logic [ID_W-1:0]   cwid;
    seg_cache_t        cwd;
    seg_cache_t        rd_entry, mg_entry;
    logic              id_ok, start_stack;

    seg_sel_check u_sel (
        .sel         (sel_in),
        .gbase       (q.gbase),
        .glimit      (q.glimit),
        .lbase       (q.lbase),
        .llimit      (q.llimit),
        .lvalid      (q.lvalid),
        .is_null     (sc_null),
        .bound_fault (sc_bound),
        .desc_addr   (sc_addr)
    );

    seg_desc_check u_desc (
        .lo       (q.lo),
        .hi       (q.hi),
        .sel      (q.sel),
        .cpl      (q.cpl),
        .is_stack (q.id == ID_W'(STACK_ID)),
        .kind     (dc_kind),
        .need_wb  (dc_wb),
        .wb_word  (dc_wword),
        .entry    (dc_entry)
    );

    seg_cache_file #(.NUM_SEG(NUM_SEG), .ID_W(ID_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cwe),
        .wid      (cwid),
        .wdata    (cwd),
        .rd_id    (rd_id),
        .rd_entry (rd_entry),
        .mg_id    (seg_id),
        .mg_entry (mg_entry)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.fault    = 1'b0;
        cwe        = 1'b0;
        cwid       = q.id;
        cwd        = dc_entry;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = q.addr;
        mem_req_wdata = q.wdata;
        id_ok       = ({1'b0, seg_id} < (ID_W+1)'(NUM_SEG));
        start_stack = (seg_id == ID_W'(STACK_ID));

        if (tbl_we) begin
            if (tbl_local) begin
                d.lbase  = tbl_base;
                d.llimit = tbl_limit;
                d.lvalid = tbl_valid;
            end else begin
                d.gbase  = tbl_base;
                d.glimit = tbl_limit;
            end
        end

        case (q.st)
            S_IDLE: begin
                if (start && id_ok) begin
                    cwid = seg_id;
                    if (mode == 2'b00) begin
                        // real mode: keep size and rights, refresh base
                        cwe       = 1'b1;
                        cwd       = mg_entry;
                        cwd.valid = 1'b1;
                        cwd.sel   = sel_in;
                        cwd.base  = {12'h000, sel_in, 4'h0};
                        cwd.attr  = mg_entry.attr | 8'h91;
                        d.done    = 1'b1;
                    end else if (mode[1]) begin
                        // virtual-8086: fixed 64 KiB writable data segment
                        cwe       = 1'b1;
                        cwd.valid = 1'b1;
                        cwd.sel   = sel_in;
                        cwd.base  = {12'h000, sel_in, 4'h0};
                        cwd.limit = 32'h0000_FFFF;
                        cwd.attr  = 8'hF3;
                        cwd.flags = 3'b000;
                        d.done    = 1'b1;
                    end else if (sc_null) begin
                        if (start_stack) begin
                            d.fault = 1'b1;
                            d.kind  = FK_GP;
                            d.code  = '0;
                        end else begin
                            cwe       = 1'b1;
                            cwd       = mg_entry;
                            cwd.valid = 1'b0;
                            cwd.sel   = '0;
                            d.done    = 1'b1;
                        end
                    end else if (sc_bound) begin
                        d.fault = 1'b1;
                        d.kind  = FK_GP;
                        d.code  = {sel_in[SEL_W-1:2], 2'b00};
                    end else begin
                        d.st   = S_RD_LO;
                        d.id   = seg_id;
                        d.sel  = sel_in;
                        d.cpl  = cpl;
                        d.addr = sc_addr;
                    end
                end
            end
            S_RD_LO: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = S_WT_LO;
            end
            S_WT_LO: begin
                if (mem_rsp_valid) begin
                    d.lo = mem_rsp_data;
                    d.st = S_RD_HI;
                end
            end
            S_RD_HI: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.addr + 32'd4;
                if (mem_req_ready) d.st = S_WT_HI;
            end
            S_WT_HI: begin
                if (mem_rsp_valid) begin
                    d.hi = mem_rsp_data;
                    d.st = S_CHECK;
                end
            end
            S_CHECK: begin
                if (dc_kind != FK_NONE) begin
                    d.fault = 1'b1;
                    d.kind  = dc_kind;
                    d.code  = {q.sel[SEL_W-1:2], 2'b00};
                    d.st    = S_IDLE;
                end else begin
                    cwe = 1'b1;
                    cwd = dc_entry;
                    if (dc_wb) begin
                        d.wdata = dc_wword;
                        d.st    = S_WBACK;
                    end else begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = q.addr + 32'd4;
                if (mem_req_ready) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.kind <= FK_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != S_IDLE);
    assign done       = q.done;
    assign fault      = q.fault;
    assign fault_kind = q.kind;
    assign fault_code = q.code;
    assign rd_valid   = rd_entry.valid;
    assign rd_sel     = rd_entry.sel;
    assign rd_base    = rd_entry.base;
    assign rd_limit   = rd_entry.limit;
    assign rd_attr    = rd_entry.attr;
    assign rd_flags   = rd_entry.flags;

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || fault));

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    assert_req_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    assert_wb_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[8]);

    assert_fault_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !$past(cwe));

endmodule

// File: tb/seg_loader_test.sv
module seg_loader_test;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [2:0] ID_ES = 3'd0, ID_SS = 3'd1, ID_DS = 3'd2, ID_FS = 3'd3, ID_GS = 3'd4;
    localparam logic [31:0] GT = 32'h100, LT = 32'h800;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, tbl_we = 0, tbl_local = 0, tbl_valid = 0;
    logic [2:0] seg_id = 0, rd_id = 0;
    logic [15:0] sel_in = 0;
    logic [1:0] mode = 0, cpl = 0;
    logic [31:0] tbl_base = 0, tbl_limit = 0;
    logic busy, done, fault, mem_req_valid, mem_req_write, rd_valid;
    logic [1:0] fault_kind;
    logic [15:0] fault_code, rd_sel;
    logic [31:0] mem_req_addr, mem_req_wdata, rd_base, rd_limit;
    logic [7:0] rd_attr;
    logic [2:0] rd_flags;
    logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 0;

    logic [31:0] mem [0:1023];
    logic bd_we = 0; logic [31:0] bd_a = 0, bd_v = 0;
    int rd_cnt = 0, wr_cnt = 0, stall_ctr = 0;
    logic stall_en = 0;
    logic [31:0] first_rd_a = 0, last_rd_a = 0, last_wr_a = 0;
    int errs = 0, checks = 0;

    logic r_done, r_fault, r_busy0; logic [1:0] r_kind; logic [15:0] r_code;
    int r_lat, r_rd, r_wr;

    seg_loader uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        stall_ctr     <= (stall_ctr == 2) ? 0 : stall_ctr + 1;
        mem_req_ready <= !stall_en || (stall_ctr == 2);
        if (bd_we) mem[bd_a[11:2]] <= bd_v;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[11:2]] <= mem_req_wdata;
                wr_cnt    <= wr_cnt + 1;
                last_wr_a <= mem_req_addr;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr[11:2]];
                rd_cnt        <= rd_cnt + 1;
                last_rd_a     <= mem_req_addr;
                if (rd_cnt % 2 == 0) first_rd_a <= mem_req_addr;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] a, input logic [31:0] v);
        bd_we = 1; bd_a = a; bd_v = v;
        @(negedge clk); bd_we = 0;
    endtask

    task automatic put_desc(input logic [31:0] tbl, input int idx, input logic [7:0] acc,
                            input logic [31:0] base, input logic [19:0] lim, input logic g, input logic db);
        put_word(tbl + idx*8, {base[15:0], lim[15:0]});
        put_word(tbl + idx*8 + 4, {base[31:24], g, db, 2'b00, lim[19:16], acc, base[23:16]});
    endtask

    task automatic set_tbl(input logic loc, input logic v, input logic [31:0] b, input logic [31:0] l);
        tbl_we = 1; tbl_local = loc; tbl_valid = v; tbl_base = b; tbl_limit = l;
        @(negedge clk); tbl_we = 0;
    endtask

    task automatic load(input logic [2:0] id, input logic [15:0] s, input logic [1:0] md, input logic [1:0] cp);
        int rd0, wr0;
        rd0 = rd_cnt; wr0 = wr_cnt;
        start = 1; seg_id = id; sel_in = s; mode = md; cpl = cp;
        @(negedge clk); start = 0;
        r_busy0 = busy; r_lat = 0;
        while (!(done || fault) && r_lat < 60) begin @(negedge clk); r_lat++; end
        if (r_lat >= 60) chk("R11", "load timeout", 0, 1);
        r_done = done; r_fault = fault; r_kind = fault_kind; r_code = fault_code;
        r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
    endtask

    task automatic peek(input logic [2:0] id);
        rd_id = id; #1;
    endtask

    function automatic logic [31:0] scaled(input logic [19:0] l, input logic g, input logic ed);
        if (!g) return {12'h0, l};
        return ed ? {l, 12'h000} : {l, 12'hFFF};
    endfunction

    task automatic t_reset;
        chk("R12", "busy", busy, 0); chk("R12", "done", done, 0); chk("R12", "fault", fault, 0);
        chk("R12", "req valid", mem_req_valid, 0);
        for (int i = 0; i < 5; i++) begin
            peek(3'(i)); chk("R12", "entry valid", rd_valid, 0); chk("R12", "entry base", rd_base, 0);
        end
        load(ID_DS, 16'h0008, 2'd1, 2'd0);
        chk("R12", "zero global bound gp", {r_fault, r_kind, r_code}, {1'b1, 2'd1, 16'h0008});
    endtask

    task automatic t_real_fresh;
        load(ID_GS, 16'h1234, 2'd0, 2'd0);
        chk("R9", "done next cycle", {r_done, r_lat[3:0], r_busy0}, {1'b1, 4'd0, 1'b0});
        peek(ID_GS);
        chk("R9", "base", rd_base, 32'h12340); chk("R9", "attr", rd_attr, 8'h91);
        chk("R9", "sel/valid", {rd_valid, rd_sel}, {1'b1, 16'h1234});
    endtask

    task automatic t_data_load;
        load(ID_DS, 16'h000B, 2'd1, 2'd0);
        chk("R7", "data done with writeback", {r_done, r_rd[3:0], r_wr[3:0]}, {1'b1, 4'd2, 4'd1});
        chk("R1", "low word address", first_rd_a, GT + 8);
        chk("R1", "high word address", last_rd_a, GT + 12);
        chk("R7", "writeback address", last_wr_a, GT + 12);
        chk("R7", "accessed bit in memory", mem[(GT+12)>>2][8], 1);
        peek(ID_DS);
        chk("R4", "base", rd_base, 32'h12345678);
        chk("R4", "scaled limit", rd_limit, scaled(20'hABCDE, 1, 0));
        chk("R4", "attr", rd_attr, 8'hF3); chk("R4", "flags", rd_flags, 3'b110);
        chk("R4", "sel", rd_sel, 16'h000B);
    endtask

    task automatic t_no_wb_and_b2b;
        load(ID_GS, 16'h0010, 2'd1, 2'd0);
        chk("R7", "accessed data no write", {r_done, r_wr[3:0]}, {1'b1, 4'd0});
        chk("R11", "latency", r_lat, 5);
        chk("R11", "busy after accept", r_busy0, 1);
        // issued in the same cycle as the previous done pulse
        load(ID_FS, 16'h0018, 2'd1, 2'd0);
        chk("R11", "start on done cycle accepted", r_done, 1);
        peek(ID_GS); chk("R4", "byte limit", rd_limit, 32'h00000FFF);
        peek(ID_FS); chk("R4", "expand-down limit", rd_limit, scaled(20'h00010, 1, 1));
    endtask

    task automatic t_real_keep;
        load(ID_FS, 16'h0ABC, 2'd0, 2'd0);
        peek(ID_FS);
        chk("R9", "limit kept", rd_limit, 32'h00010000);
        chk("R9", "attr kept with p/s/a", rd_attr, 8'h97);
        chk("R9", "base", rd_base, 32'h0ABC0);
    endtask

    task automatic t_stack;
        load(ID_SS, 16'h0020, 2'd1, 2'd0);
        chk("R7", "stack always writes", {r_done, r_wr[3:0]}, {1'b1, 4'd1});
        load(ID_SS, 16'h0021, 2'd1, 2'd0);
        chk("R5", "rpl mismatch", {r_fault, r_kind, r_code}, {1'b1, 2'd1, 16'h0020});
        load(ID_SS, 16'h0028, 2'd1, 2'd0);
        chk("R5", "code segment", {r_fault, r_kind, r_code}, {1'b1, 2'd1, 16'h0028});
        load(ID_SS, 16'h0030, 2'd1, 2'd0);
        chk("R5", "dpl mismatch", {r_fault, r_kind, r_code}, {1'b1, 2'd1, 16'h0030});
        load(ID_SS, 16'h0038, 2'd1, 2'd0);
        chk("R5", "not present", {r_fault, r_kind, r_code}, {1'b1, 2'd2, 16'h0038});
        load(ID_SS, 16'h003B, 2'd1, 2'd0);
        chk("R5", "privilege before presence", {r_fault, r_kind}, {1'b1, 2'd1});
        chk("R8", "no write on fault", r_wr, 0);
        peek(ID_SS);
        chk("R8", "stack entry unchanged", {rd_valid, rd_sel, rd_base}, {1'b1, 16'h0020, 32'h2000});
        load(ID_SS, 16'h0000, 2'd1, 2'd0);
        chk("R2", "null stack gp 0", {r_fault, r_kind, r_code, r_rd[3:0]}, {1'b1, 2'd1, 16'h0, 4'd0});
    endtask

    task automatic t_bounds;
        load(ID_DS, 16'h0044, 2'd1, 2'd0);
        chk("R3", "local table invalid", {r_fault, r_kind, r_code, r_rd[3:0]}, {1'b1, 2'd1, 16'h0044, 4'd0});
        load(ID_DS, 16'h0042, 2'd1, 2'd0);
        chk("R3", "global bound exceeded", {r_fault, r_code, r_rd[3:0]}, {1'b1, 16'h0040, 4'd0});
        load(ID_GS, 16'h0038, 2'd1, 2'd0);
        chk("R3", "last slot passes bound, then np", {r_fault, r_kind, r_rd[3:0]}, {1'b1, 2'd3, 4'd2});
        set_tbl(1'b1, 1'b1, LT, 32'h1F);
        load(ID_DS, 16'h0024, 2'd1, 2'd0);
        chk("R3", "local bound exceeded", {r_fault, r_code, r_rd[3:0]}, {1'b1, 16'h0024, 4'd0});
    endtask

    task automatic t_data_rules;
        load(ID_DS, 16'h0004, 2'd1, 2'd0);
        chk("R6", "execute-only code", {r_fault, r_kind, r_code}, {1'b1, 2'd1, 16'h0004});
        load(ID_DS, 16'h000F, 2'd1, 2'd3);
        chk("R6", "conforming readable code ok", r_done, 1);
        chk("R1", "local low address", first_rd_a, LT + 8);
        peek(ID_DS); chk("R1", "local base", rd_base, 32'h3000);
        load(ID_ES, 16'h0017, 2'd1, 2'd0);
        chk("R6", "rpl above dpl", {r_fault, r_code}, {1'b1, 16'h0014});
        load(ID_ES, 16'h0014, 2'd1, 2'd3);
        chk("R6", "cpl above dpl", {r_fault, r_kind}, {1'b1, 2'd1});
        load(ID_ES, 16'h001F, 2'd1, 2'd0);
        chk("R6", "non-conforming code privilege", {r_fault, r_kind}, {1'b1, 2'd1});
        load(ID_DS, 16'h0003, 2'd1, 2'd0);
        chk("R2", "null data done no access", {r_done, r_rd[3:0]}, {1'b1, 4'd0});
        peek(ID_DS); chk("R2", "null clears valid", {rd_valid, rd_sel}, {1'b0, 16'h0});
    endtask

    task automatic t_v86;
        load(ID_ES, 16'hBEEF, 2'd2, 2'd3);
        chk("R10", "done next cycle", {r_done, r_lat[3:0], r_busy0}, {1'b1, 4'd0, 1'b0});
        peek(ID_ES);
        chk("R10", "base/limit", {rd_base, rd_limit}, {32'hBEEF0, 32'hFFFF});
        chk("R10", "attr/flags", {rd_attr, rd_flags}, {8'hF3, 3'b000});
    endtask

    task automatic t_busy_ignore;
        stall_en = 1;
        start = 1; seg_id = ID_DS; sel_in = 16'h000B; mode = 2'd1; cpl = 2'd0;
        @(negedge clk);
        chk("R11", "busy", busy, 1);
        seg_id = ID_ES; sel_in = 16'h7777; mode = 2'd0;
        @(negedge clk); start = 0;
        for (int n = 0; n < 60 && !done && !fault; n++) @(negedge clk);
        chk("R13", "stalled load completes", done, 1);
        stall_en = 0;
        peek(ID_ES);
        chk("R11", "start while busy ignored", {rd_sel, rd_base}, {16'hBEEF, 32'hBEEF0});
        peek(ID_DS); chk("R13", "stalled base", rd_base, 32'h12345678);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        put_desc(GT, 1, 8'hF2, 32'h12345678, 20'hABCDE, 1, 1);
        put_desc(GT, 2, 8'h93, 32'h00001000, 20'h00FFF, 0, 0);
        put_desc(GT, 3, 8'h96, 32'h00005000, 20'h00010, 1, 0);
        put_desc(GT, 4, 8'h93, 32'h00002000, 20'h0FFFF, 0, 1);
        put_desc(GT, 5, 8'h9A, 32'h0, 20'hFFFFF, 1, 1);
        put_desc(GT, 6, 8'hF3, 32'h0, 20'hFFFFF, 1, 1);
        put_desc(GT, 7, 8'h13, 32'h0, 20'hFFFFF, 1, 1);
        put_desc(LT, 0, 8'h98, 32'h0, 20'h0FFFF, 0, 0);
        put_desc(LT, 1, 8'h9E, 32'h00003000, 20'h001FF, 0, 0);
        put_desc(LT, 2, 8'h93, 32'h0, 20'h0FFFF, 0, 0);
        put_desc(LT, 3, 8'h9B, 32'h0, 20'h0FFFF, 0, 0);
        t_reset;
        set_tbl(1'b0, 1'b0, GT, 32'h3F);
        t_real_fresh;
        t_data_load;
        t_no_wb_and_b2b;
        t_real_keep;
        t_stack;
        t_bounds;
        t_data_rules;
        t_v86;
        t_busy_ignore;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule